// File: doc/BRIEF.md
# Dot-Matrix Row Scan and Brightness Timer

This block provides the multiplex timing for a four-character display. Each character is a 5-column by 7-row dot array, and all characters share one set of row drivers. A single timebase step, called a tick, moves the block through a fixed row slot. A row slot has one blanking tick followed by four lit sub-slots. When a row slot ends, the row counter moves to the next row. It counts 0 to 6 and then wraps to 0. Two dot-enable gates come out of the block:

- one gate follows a 2-bit brightness code;
- the other gate always gives half on-time, for lamp-test and cursor dots.

A slow blink phase, counted in ticks, is shared with the attribute logic.

The tick can come from two places:

- an internal divider of the system clock. In this case the block drives the tick out, with an enable, so that other units can use it;
- an external tick line, for a unit that follows another one. In this case the block advances on each rising edge of that line.

A synchronous reset clears all counters. When cascaded units share this reset and the same tick, they scan and blink in step.

Top module: `led_scan_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counters clear. After that edge `row_sel` is 0, `row_idx` is 0, `blink_phase` is 0, and both gates are 0.
- R2: With `tick_sel`=1, `tick_oe`=1 and `tick_out` pulses high for one clock every `DIV_CYCLES` clocks. With `tick_sel`=0, `tick_out` and `tick_oe` stay 0 and the block advances once per rising edge of `tick_in`. A level held high counts once.
- R3: With `tick_sel`=1, activity on `tick_in` has no effect on the scan or blink state.
- R4: A row slot lasts SUB_SLOTS+1 ticks. In the first (blanking) tick `row_sel` is all zero and both gates are 0. In the remaining ticks only `row_sel[row_idx]` is set.
- R5: `row_idx` moves 0,1,...,NUM_ROWS-1 and then wraps to 0, advancing when the tick that ends a row slot arrives.
- R6: Numbering the lit sub-slots from 0, `dot_gate` is high in sub-slots below an on-count. The on-count is set by `bright`: 2'b00 gives 0, 2'b01 gives SUB_SLOTS/4, 2'b10 gives SUB_SLOTS/2, and 2'b11 gives SUB_SLOTS.
- R7: `dot_gate_half` is high in lit sub-slots below SUB_SLOTS/2, whatever `bright` is.
- R8: `blink_phase` toggles after every `BLINK_TICKS` ticks counted from reset, and changes at no other time.
- R9: A reset applied partway through a scan restarts the row, sub-slot and blink counts from zero. The block then follows the same sequence as after a fresh reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low counter reset |
| tick_sel | input | 1 | 1: internal divider is the tick source; 0: follow `tick_in` |
| tick_in | input | 1 | External tick line, rising edge counts (clock domain of `clk`) |
| bright | input | 2 | Brightness code |
| tick_out | output | 1 | Internal tick pulse for other units |
| tick_oe | output | 1 | Drive enable for the shared tick line |
| row_sel | output | NUM_ROWS (7) | One-hot row drive, zero while blanking |
| row_idx | output | $clog2(NUM_ROWS) (3) | Current row number |
| dot_gate | output | 1 | Column enable at the coded brightness |
| dot_gate_half | output | 1 | Column enable at half brightness |
| blink_phase | output | 1 | Slow blink phase |

## Verification
The bench builds the block with `DIV_CYCLES`=3 and `BLINK_TICKS`=10, and keeps seven rows and four sub-slots. With these values the internal tick arrives every third clock, so a count of `tick_out` pulses over a short window is exact. Blink toggles fall within a few dozen ticks, so the bench can check both sides of each toggle. A full seven-row wrap takes only 35 ticks. Driving the external tick by hand lets the bench check each sub-slot's gate for all four brightness codes.

// File: rtl/led_scan_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the row scan timer.
// Assumes the brightness code is a plain 2-bit value from a control register.
package led_scan_pkg;

    typedef enum logic [1:0] {
        BRT_OFF     = 2'b00,
        BRT_QUARTER = 2'b01,
        BRT_HALF    = 2'b10,
        BRT_FULL    = 2'b11
    } bright_e;

    // Number of lit sub-slots for a brightness code.
    function automatic int on_slots(input bright_e code, input int slots);
        int n;
        case (code)
            BRT_OFF:     n = 0;
            BRT_QUARTER: n = slots / 4;
            BRT_HALF:    n = slots / 2;
            default:     n = slots;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_tick_source.sv
`timescale 1ns/1ps
// Picks the scan timebase: an internal clock divider, or the rising edge of
// an external tick line. When the divider is the source, its tick is driven
// out for other units to use.
// Assumes tick_in is already synchronous to clk.
module scan_tick_source #(
    parameter int DIV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_sel,
    input  logic tick_in,
    output logic tick_out,
    output logic tick_oe,
    output logic step
);
    localparam int DW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_CYCLES - 1);

    logic [DW-1:0] div_q;
    logic          int_tick;
    logic          ext_q;
    logic          ext_edge;

    // Terminal count of the divider.
    always_comb int_tick = (div_q == DIV_LAST);

    // Free-running divider, restarted by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (int_tick) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Previous level of the external tick, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= tick_in;
    end

    // Rising edge of the external line.
    always_comb ext_edge = tick_in & ~ext_q;

    // Source selection and cascade outputs.
    always_comb begin
        step     = tick_sel ? int_tick : ext_edge;
        tick_out = tick_sel & int_tick;
        tick_oe  = tick_sel;
    end

endmodule

// File: rtl/scan_row_sequencer.sv
`timescale 1ns/1ps
// Steps through row slots. Each slot is one blanking tick followed by
// SUB_SLOTS lit ticks. Decodes the one-hot row drive and both dot gates.
// Assumes step is a single-cycle pulse.
module scan_row_sequencer
    import led_scan_pkg::*;
#(
    parameter int NUM_ROWS  = 7,
    parameter int SUB_SLOTS = 4,
    parameter int RW        = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [1:0]          bright,
    output logic [NUM_ROWS-1:0] row_sel,
    output logic [RW-1:0]       row_idx,
    output logic                dot_gate,
    output logic                dot_gate_half
);
    localparam int PW = $clog2(SUB_SLOTS + 1);
    localparam logic [PW-1:0] PH_LAST  = PW'(SUB_SLOTS);
    localparam logic [RW-1:0] ROW_LAST = RW'(NUM_ROWS - 1);

    logic [PW-1:0] phase_q;
    logic [RW-1:0] row_q;
    logic          lit;
    int            sub;

    // Phase and row counters, advanced once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            row_q   <= '0;
        end else if (step) begin
            if (phase_q == PH_LAST) begin
                phase_q <= '0;
                row_q   <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Lit-interval flag and sub-slot index.
    always_comb begin
        lit = (phase_q != '0);
        sub = int'(phase_q) - 1;
    end

    // One-hot row decode, blank during the gap tick.
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        always_comb row_sel[r] = lit && (row_q == RW'(r));
    end

    // Duty-cycle gates for the coded level and the fixed half level.
    always_comb begin
        dot_gate      = lit && (sub < on_slots(bright_e'(bright), SUB_SLOTS));
        dot_gate_half = lit && (sub < SUB_SLOTS / 2);
        row_idx       = row_q;
    end

endmodule

// File: rtl/scan_blink_divider.sv
`timescale 1ns/1ps
// Counts scan ticks and toggles the shared blink phase every BLINK_TICKS.
// Assumes step is a single-cycle pulse.
module scan_blink_divider #(
    parameter int BLINK_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic blink_phase
);
    localparam int BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [BW-1:0] CNT_LAST = BW'(BLINK_TICKS - 1);

    logic [BW-1:0] cnt_q;
    logic          ph_q;

    // Tick counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (step) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                ph_q  <= ~ph_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Registered phase out.
    always_comb blink_phase = ph_q;

endmodule

// File: rtl/led_scan_timer.sv
`timescale 1ns/1ps
// Top of the row scan and brightness timer: tick source, row sequencer and
// blink divider. All counters share one synchronous active-low reset, so
// units that share the reset and the tick stay in step.
// Assumes all inputs are synchronous to clk.
module led_scan_timer #(
    parameter int DIV_CYCLES  = 1000,
    parameter int BLINK_TICKS = 5000,
    parameter int NUM_ROWS    = 7,
    parameter int SUB_SLOTS   = 4,
    parameter int RW          = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_sel,
    input  logic                tick_in,
    input  logic [1:0]          bright,
    output logic                tick_out,
    output logic                tick_oe,
    output logic [NUM_ROWS-1:0] row_sel,
    output logic [RW-1:0]       row_idx,
    output logic                dot_gate,
    output logic                dot_gate_half,
    output logic                blink_phase
);
    logic step;

    // Timebase selection.
    scan_tick_source #(.DIV_CYCLES(DIV_CYCLES)) u_src (
        .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .tick_in(tick_in),
        .tick_out(tick_out), .tick_oe(tick_oe), .step(step)
    );

    // Row and sub-slot timing.
    scan_row_sequencer #(.NUM_ROWS(NUM_ROWS), .SUB_SLOTS(SUB_SLOTS), .RW(RW)) u_seq (
        .clk(clk), .rst_n(rst_n), .step(step), .bright(bright),
        .row_sel(row_sel), .row_idx(row_idx),
        .dot_gate(dot_gate), .dot_gate_half(dot_gate_half)
    );

    // Blink phase.
    scan_blink_divider #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
        .clk(clk), .rst_n(rst_n), .step(step), .blink_phase(blink_phase)
    );

endmodule

// File: rtl/led_scan_timer_checker.sv
`timescale 1ns/1ps
// Property checks for led_scan_timer, attached with bind.
module led_scan_timer_checker #(
    parameter int NUM_ROWS = 7,
    parameter int RW       = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_sel,
    input logic                tick_out,
    input logic                tick_oe,
    input logic                step,
    input logic [1:0]          bright,
    input logic [NUM_ROWS-1:0] row_sel,
    input logic [RW-1:0]       row_idx,
    input logic                dot_gate,
    input logic                dot_gate_half,
    input logic                blink_phase
);
    assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    assert_gate_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_gate || dot_gate_half) |-> (row_sel != '0));

    assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_idx));

    assert_row_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= RW'(NUM_ROWS - 1));

    assert_blank_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bright == 2'b00) |-> !dot_gate);

    assert_half_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bright == 2'b10) |-> (dot_gate == dot_gate_half));

    assert_follower_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_sel |-> (!tick_out && !tick_oe));

    assert_blink_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(blink_phase));

endmodule

bind led_scan_timer led_scan_timer_checker #(.NUM_ROWS(NUM_ROWS), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .tick_out(tick_out),
    .tick_oe(tick_oe), .step(step), .bright(bright), .row_sel(row_sel),
    .row_idx(row_idx), .dot_gate(dot_gate), .dot_gate_half(dot_gate_half),
    .blink_phase(blink_phase)
);

// File: tb/led_scan_timer_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module led_scan_timer_bench;
    localparam int DIV   = 3;
    localparam int BLINK = 10;
    localparam int ROWS  = 7;
    localparam int SUBS  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_sel = 1'b0;
    logic            tick_in = 1'b0;
    logic [1:0]      bright = 2'b11;
    logic            tick_out, tick_oe, dot_gate, dot_gate_half, blink_phase;
    logic [ROWS-1:0] row_sel;
    logic [2:0]      row_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    int m_phase, m_row, m_bcnt;
    bit m_blink;

    always #5 clk = ~clk;

    led_scan_timer #(.DIV_CYCLES(DIV), .BLINK_TICKS(BLINK), .NUM_ROWS(ROWS),
                     .SUB_SLOTS(SUBS)) u_led_scan_timer (
        .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .tick_in(tick_in),
        .bright(bright), .tick_out(tick_out), .tick_oe(tick_oe),
        .row_sel(row_sel), .row_idx(row_idx), .dot_gate(dot_gate),
        .dot_gate_half(dot_gate_half), .blink_phase(blink_phase)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_row = 0; m_bcnt = 0; m_blink = 0;
    endtask

    task automatic model_step();
        if (m_phase == SUBS) begin
            m_phase = 0;
            m_row   = (m_row == ROWS - 1) ? 0 : m_row + 1;
        end else m_phase++;
        if (m_bcnt == BLINK - 1) begin
            m_bcnt = 0; m_blink = !m_blink;
        end else m_bcnt++;
    endtask

    function automatic int exp_row_sel();
        return (m_phase == 0) ? 0 : (1 << m_row);
    endfunction

    function automatic int exp_gate(input int code);
        int onc;
        onc = (code == 0) ? 0 : (code == 1) ? SUBS / 4 : (code == 2) ? SUBS / 2 : SUBS;
        return (m_phase != 0 && (m_phase - 1) < onc) ? 1 : 0;
    endfunction

    function automatic int exp_half();
        return (m_phase != 0 && (m_phase - 1) < SUBS / 2) ? 1 : 0;
    endfunction

    task automatic do_reset(input bit sel);
        @(negedge clk);
        rst_n = 1'b0; tick_in = 1'b0; tick_sel = sel;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic ext_tick();
        @(negedge clk) tick_in = 1'b1;
        @(negedge clk) tick_in = 1'b0;
        model_step();
    endtask

    task automatic compare_scan(input string req);
        check({req, " row_sel"}, int'(row_sel), exp_row_sel());
        check({req, " row_idx"}, int'(row_idx), m_row);
    endtask

    // R1: cleared state after reset
    task automatic t_reset();
        do_reset(1'b0);
        check("R1 row_sel", int'(row_sel), 0);
        check("R1 row_idx", int'(row_idx), 0);
        check("R1 blink", int'(blink_phase), 0);
        check("R1 dot_gate", int'(dot_gate), 0);
        check("R1 dot_gate_half", int'(dot_gate_half), 0);
    endtask

    // R4, R5: full scan of all rows and the wrap
    task automatic t_scan();
        do_reset(1'b0);
        bright = 2'b11;
        for (int i = 0; i < ROWS * (SUBS + 1) + 3; i++) begin
            ext_tick();
            compare_scan("R4/R5 scan");
        end
        check("R5 wrapped row", int'(row_idx), 0);
    endtask

    // R6, R7: gates per sub-slot for each code
    task automatic t_brightness();
        for (int code = 0; code < 4; code++) begin
            do_reset(1'b0);
            bright = 2'(code);
            for (int p = 0; p <= SUBS; p++) begin
                if (p != 0) ext_tick();
                check($sformatf("R6 code%0d phase%0d", code, m_phase), int'(dot_gate), exp_gate(code));
                check($sformatf("R7 code%0d phase%0d", code, m_phase), int'(dot_gate_half), exp_half());
            end
        end
        bright = 2'b11;
    endtask

    // R2: follower mode outputs quiet, held level counts once
    task automatic t_follower();
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R2 tick_out quiet", int'(tick_out), 0);
        end
        check("R2 tick_oe low", int'(tick_oe), 0);
        compare_scan("R2 no spontaneous step");
        @(negedge clk) tick_in = 1'b1;
        repeat (4) @(negedge clk);
        tick_in = 1'b0;
        model_step();
        @(negedge clk);
        compare_scan("R2 held level one step");
    endtask

    // R2, R3: internal source, tick_in toggled and ignored
    task automatic t_internal();
        int pulses = 0;
        do_reset(1'b1);
        for (int i = 0; i < DIV * 10; i++) begin
            @(negedge clk);
            tick_in = i[0];
            if (tick_out) begin
                pulses++;
                model_step();
            end
        end
        tick_in = 1'b0;
        check("R2 tick_oe high", int'(tick_oe), 1);
        check("R2 pulse count", pulses, 10);
        @(negedge clk);
        if (tick_out) model_step();
        compare_scan("R3 tick_in ignored");
        check("R3 blink", int'(blink_phase), int'(m_blink));
        tick_sel = 1'b0;
    endtask

    // R8: blink toggle points
    task automatic t_blink();
        do_reset(1'b0);
        for (int i = 1; i <= 2 * BLINK + 1; i++) begin
            ext_tick();
            if (i == BLINK - 1 || i == BLINK || i == 2 * BLINK - 1 || i == 2 * BLINK)
                check($sformatf("R8 blink after %0d", i), int'(blink_phase), int'(m_blink));
        end
    endtask

    // R9: reset mid-scan restarts all counts
    task automatic t_resync();
        do_reset(1'b0);
        for (int i = 0; i < 13; i++) ext_tick();
        do_reset(1'b0);
        compare_scan("R9 after reset");
        check("R9 blink cleared", int'(blink_phase), 0);
        for (int i = 0; i < BLINK; i++) ext_tick();
        check("R9 blink realigned", int'(blink_phase), 1);
        compare_scan("R9 scan realigned");
    endtask

    initial begin
        model_reset();
        t_reset();
        t_scan();
        t_brightness();
        t_follower();
        t_internal();
        t_blink();
        t_resync();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule